// File: doc/BRIEF.md
# Serial Management Frame Slave

This block is the slave end of a two-wire serial management link. It uses the management clock as its own clock and samples the data line once per rising edge. Frames in the common 22-style layout are decoded into register-file accesses. A frame has a 2-bit opcode, a 5-bit device address and a 5-bit register address, all sent most significant bit first. Any device address is accepted, so the block answers every frame on the wire.

A frame needs no long run of ones in front of it. While idle, the block waits for a 0. It then waits for the first 1 after that 0, and that 1 begins the header. On a read, the block fetches the register when the header ends. It drives one turnaround bit low and then shifts out sixteen data bits. On a write, it skips two turnaround bits, shifts in sixteen data bits and then issues a single write to the register file. An opcode that is neither read nor write sends the block straight back to idle.

The register file sits behind a simple strobe interface. In the cycle where `rd_stb` is high, it returns `rd_data` combinationally for the address on `reg_addr`. It captures `wr_data` on the clock edge that ends a `wr_stb` cycle.

Top module: `mdio_frame_slave`

## Requirements
- R1: A synchronous reset returns the block to idle. In the cycle after reset is released, `mdio_oe`, `wr_stb` and `rd_stb` are all low.
- R2: While idle, a sampled 1 leaves the block idle. A sampled 0 arms it. Further 0s keep it armed, and the first 1 after them begins a 12-bit header.
- R3: The header arrives MSB first: opcode[1:0], then device address[4:0], then register address[4:0]. The device address has no effect, so a frame with any device address is served.
- R4: For opcode binary 10 (read), in the cycle after the last header bit is sampled, `rd_stb` is high for exactly one cycle and `reg_addr` equals the register address. In that same cycle `mdio_oe` is high and `mdio_out` is 0 (the turnaround bit).
- R5: Read data is driven MSB first on the 16 cycles after the turnaround. `mdio_oe` stays high for exactly 17 consecutive cycles and is low in the cycle after them.
- R6: For opcode binary 01 (write), the next two sampled bits are ignored whatever their value. The following 16 bits form the write word, MSB first. One cycle after the last data bit, `wr_stb` is high for exactly one cycle, with `reg_addr` and `wr_data` holding the frame's register address and data.
- R7: Opcodes 00 and 11 return the block to idle. Neither strobe is raised, the line is not driven, and no register changes.
- R8: `mdio_oe` is never high outside a read window; it is never high during write frames or while idle.
- R9: The block is idle in the cycle after the last bit of a frame. A 0 sampled there arms it, so frames may follow back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Management clock; the data line is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mdio_in | input | 1 | Sampled level of the serial data line |
| mdio_out | output | 1 | Bit driven onto the line during a read |
| mdio_oe | output | 1 | Output enable for `mdio_out` |
| reg_addr | output | REG_AW | Register address of the current access |
| wr_data | output | DATA_W | Write word, valid with `wr_stb` |
| wr_stb | output | 1 | One-cycle register write pulse |
| rd_stb | output | 1 | One-cycle register read pulse |
| rd_data | input | DATA_W | Register contents, returned in the `rd_stb` cycle |

## Verification
The bench builds the block with its default 16-bit data, 5-bit register address and 5-bit device address. With 5 address bits the whole register space has only 32 entries, so every register is written and read back. Each sweep uses a different device address for every frame and an arithmetic data pattern, which exercises every bit lane and every address decode. Because the space is this small, the bench can also cover both illegal opcodes, both turnaround polarities, varying idle and arming runs, back-to-back reads and a reset in the middle of a frame.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_HDR,
      ST_TA_RD,
      ST_READ,
      ST_TA_WR,
      ST_WRITE
   } mfs_state_t;

   function automatic int mfs_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mfs_op_decode.sv
module mfs_op_decode #(
   parameter int              OP_W  = 2,
   parameter logic [OP_W-1:0] RD_OP = 2'b10,
   parameter logic [OP_W-1:0] WR_OP = 2'b01
) (
   input  logic [OP_W-1:0] op,
   output logic            is_rd,
   output logic            is_wr
);

   generate
      if (RD_OP == WR_OP) begin : g_bad_codes
         $error("mfs_op_decode: read and write opcodes must differ");
      end
      if (OP_W < 1) begin : g_bad_width
         $error("mfs_op_decode: opcode width must be positive");
      end
   endgenerate

   always_comb begin
      is_rd = (op == RD_OP);
      is_wr = (op == WR_OP);
   end

endmodule

// File: rtl/mfs_bit_cnt.sv
module mfs_bit_cnt #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         last
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = (cnt_q == W'(1));

endmodule

// File: rtl/mfs_shifter.sv
module mfs_shifter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   input  logic         bit_in,
   output logic [W-1:0] q,
   output logic [W-1:0] q_next_shift
);

   generate
      if (W < 2) begin : g_bad_w
         $error("mfs_shifter: width must be at least 2");
      end
   endgenerate

   logic [W-1:0] q_r;

   assign q_next_shift = {q_r[W-2:0], bit_in};
   assign q            = q_r;

   always_ff @(posedge clk) begin
      if (rst) begin
         q_r <= '0;
      end else if (load) begin
         q_r <= load_val;
      end else if (shift) begin
         q_r <= q_next_shift;
      end
   end

endmodule

// File: rtl/mdio_frame_slave.sv
module mdio_frame_slave
   import mfs_pkg::*;
#(
   parameter int              DATA_W = 16,
   parameter int              REG_AW = 5,
   parameter int              PHY_AW = 5,
   parameter int              OP_W   = 2,
   parameter logic [OP_W-1:0] RD_OP  = 2'b10,
   parameter logic [OP_W-1:0] WR_OP  = 2'b01,
   parameter int              WR_TA  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              mdio_in,
   output logic              mdio_out,
   output logic              mdio_oe,
   output logic [REG_AW-1:0] reg_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              wr_stb,
   output logic              rd_stb,
   input  logic [DATA_W-1:0] rd_data
);

   localparam int HDR_W = OP_W + PHY_AW + REG_AW;
   localparam int ACC_W = mfs_max(HDR_W, DATA_W);
   localparam int CNT_W = $clog2(mfs_max(ACC_W, WR_TA) + 1);

   generate
      if (WR_TA < 1) begin : g_bad_ta
         $error("mdio_frame_slave: write turnaround must be at least one bit");
      end
      if (DATA_W < 2 || REG_AW < 1) begin : g_bad_dims
         $error("mdio_frame_slave: data width or address width out of range");
      end
   endgenerate

   mfs_state_t state_q, state_d;

   logic              cnt_load, cnt_dec, cnt_last;
   logic [CNT_W-1:0]  cnt_val;
   logic              sh_load, sh_shift, sh_in;
   logic [ACC_W-1:0]  sh_val, acc_q, acc_next;
   logic [OP_W-1:0]   op_field;
   logic              op_rd, op_wr;
   logic [REG_AW-1:0] addr_q;
   logic              addr_load;
   logic [DATA_W-1:0] wdata_q;
   logic              wstb_q, wstb_d;

   mfs_bit_cnt #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (cnt_load),
      .load_val (cnt_val),
      .dec      (cnt_dec),
      .last     (cnt_last)
   );

   mfs_shifter #(.W(ACC_W)) u_sh (
      .clk          (clk),
      .rst          (rst),
      .load         (sh_load),
      .load_val     (sh_val),
      .shift        (sh_shift),
      .bit_in       (sh_in),
      .q            (acc_q),
      .q_next_shift (acc_next)
   );

   assign op_field = acc_next[HDR_W-1 -: OP_W];

   mfs_op_decode #(.OP_W(OP_W), .RD_OP(RD_OP), .WR_OP(WR_OP)) u_dec (
      .op    (op_field),
      .is_rd (op_rd),
      .is_wr (op_wr)
   );

   always_comb begin
      state_d   = state_q;
      cnt_load  = 1'b0;
      cnt_val   = '0;
      cnt_dec   = 1'b0;
      sh_load   = 1'b0;
      sh_val    = '0;
      sh_shift  = 1'b0;
      sh_in     = mdio_in;
      addr_load = 1'b0;
      wstb_d    = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (!mdio_in) state_d = ST_ARM;
         end
         ST_ARM: begin
            if (mdio_in) begin
               state_d  = ST_HDR;
               cnt_load = 1'b1;
               cnt_val  = CNT_W'(HDR_W);
               sh_load  = 1'b1;
            end
         end
         ST_HDR: begin
            sh_shift = 1'b1;
            cnt_dec  = 1'b1;
            if (cnt_last) begin
               if (op_rd) begin
                  state_d   = ST_TA_RD;
                  addr_load = 1'b1;
               end else if (op_wr) begin
                  state_d   = ST_TA_WR;
                  addr_load = 1'b1;
                  cnt_load  = 1'b1;
                  cnt_val   = CNT_W'(WR_TA);
               end else begin
                  state_d = ST_IDLE;
               end
            end
         end
         ST_TA_RD: begin
            state_d  = ST_READ;
            sh_load  = 1'b1;
            sh_val   = ACC_W'(rd_data);
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(DATA_W);
         end
         ST_READ: begin
            sh_shift = 1'b1;
            sh_in    = 1'b0;
            cnt_dec  = 1'b1;
            if (cnt_last) state_d = ST_IDLE;
         end
         ST_TA_WR: begin
            cnt_dec = 1'b1;
            if (cnt_last) begin
               state_d  = ST_WRITE;
               cnt_load = 1'b1;
               cnt_val  = CNT_W'(DATA_W);
            end
         end
         ST_WRITE: begin
            sh_shift = 1'b1;
            cnt_dec  = 1'b1;
            if (cnt_last) begin
               state_d = ST_IDLE;
               wstb_d  = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         wstb_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         wstb_q  <= wstb_d;
         if (addr_load) addr_q  <= acc_next[REG_AW-1:0];
         if (wstb_d)    wdata_q <= acc_next[DATA_W-1:0];
      end
   end

   assign mdio_oe  = (state_q == ST_TA_RD) || (state_q == ST_READ);
   assign mdio_out = (state_q == ST_READ) ? acc_q[DATA_W-1] : 1'b0;
   assign rd_stb   = (state_q == ST_TA_RD);
   assign wr_stb   = wstb_q;
   assign wr_data  = wdata_q;
   assign reg_addr = addr_q;

endmodule

// File: rtl/mfs_checker.sv
module mfs_checker #(
   parameter int DATA_W = 16
) (
   input logic clk,
   input logic rst,
   input logic mdio_oe,
   input logic mdio_out,
   input logic rd_stb,
   input logic wr_stb
);

   localparam int RUN_W = $clog2(DATA_W + 4) + 1;

   logic             rst_d = 1'b0;
   logic [RUN_W-1:0] oe_run;

   always_ff @(posedge clk) begin
      rst_d <= rst;
      if (rst)          oe_run <= '0;
      else if (mdio_oe) oe_run <= oe_run + 1'b1;
      else              oe_run <= '0;
   end

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      rst_d |-> (!mdio_oe && !wr_stb && !rd_stb));

   p_rd_turnaround_r4: assert property (@(posedge clk) disable iff (rst)
      rd_stb |-> (mdio_oe && !mdio_out));

   p_rd_pulse_r4: assert property (@(posedge clk) disable iff (rst)
      rd_stb |=> !rd_stb);

   p_oe_window_r5: assert property (@(posedge clk) disable iff (rst || rst_d)
      (!mdio_oe && oe_run != '0) |-> (oe_run == RUN_W'(DATA_W + 1)));

   p_wr_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      wr_stb |=> !wr_stb);

   p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
      !(wr_stb && rd_stb));

   p_no_drive_on_write_r8: assert property (@(posedge clk) disable iff (rst)
      wr_stb |-> !mdio_oe);

endmodule

bind mdio_frame_slave mfs_checker #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .mdio_oe  (mdio_oe),
   .mdio_out (mdio_out),
   .rd_stb   (rd_stb),
   .wr_stb   (wr_stb)
);

// File: tb/sim_mdio_frame_slave.sv
module sim_mdio_frame_slave;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        mdio_in = 1'b1;
   logic        mdio_out, mdio_oe, wr_stb, rd_stb;
   logic [4:0]  reg_addr;
   logic [15:0] wr_data, rd_data;
   logic [15:0] mem [32];

   int checks = 0, errors = 0;
   int oe_cycles = 0, wr_pulses = 0, rd_pulses = 0;
   int reads_done = 0, writes_done = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_frame_slave u0 (
      .clk(clk), .rst(rst), .mdio_in(mdio_in), .mdio_out(mdio_out),
      .mdio_oe(mdio_oe), .reg_addr(reg_addr), .wr_data(wr_data),
      .wr_stb(wr_stb), .rd_stb(rd_stb), .rd_data(rd_data)
   );

   assign rd_data = mem[reg_addr];
   always @(posedge clk) if (wr_stb) mem[reg_addr] <= wr_data;

   always @(negedge clk) begin
      if (!rst) begin
         if (mdio_oe) oe_cycles++;
         if (wr_stb)  wr_pulses++;
         if (rd_stb)  rd_pulses++;
      end
   end

   function automatic logic [15:0] pat(input int r, input int k);
      return 16'((r * 16'h0A3B) ^ (k * 16'h1111) ^ 16'h5A0F);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      mdio_in = b;
   endtask

   task automatic send_hdr(input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] r, input int n_ones, input int n_zeros);
      for (int i = 0; i < n_ones; i++)  send_bit(1'b1);
      for (int i = 0; i < n_zeros; i++) send_bit(1'b0);
      send_bit(1'b1);
      for (int i = 1; i >= 0; i--) send_bit(op[i]);
      for (int i = 4; i >= 0; i--) send_bit(phy[i]);
      for (int i = 4; i >= 0; i--) send_bit(r[i]);
   endtask

   // R4/R5: read frame, checking strobe, turnaround, data and release
   task automatic do_read(input logic [4:0] phy, input logic [4:0] r,
                          input int n_ones, input int n_zeros,
                          input logic [15:0] exp, input logic lead);
      logic [15:0] got;
      bit          oe_ok;
      send_hdr(2'b10, phy, r, n_ones, n_zeros);
      @(negedge clk);
      chk(rd_stb && reg_addr == r, "R4 read strobe/address", {rd_stb, 11'd0, reg_addr}, {1'b1, 11'd0, r});
      chk(mdio_oe && !mdio_out, "R4 turnaround", {mdio_oe, mdio_out}, 2'b10);
      mdio_in = 1'b1;
      oe_ok = 1'b1;
      for (int i = 15; i >= 0; i--) begin
         @(negedge clk);
         got[i] = mdio_out;
         oe_ok  = oe_ok && mdio_oe && !rd_stb;
         mdio_in = 1'b1;
      end
      chk(got == exp && oe_ok, "R5 read data", got, exp);
      @(negedge clk);
      chk(!mdio_oe, "R5 release", mdio_oe, 0);
      mdio_in = lead;
      reads_done++;
   endtask

   // R6: write frame with chosen turnaround values
   task automatic do_write(input logic [4:0] phy, input logic [4:0] r,
                           input int n_ones, input int n_zeros,
                           input logic [15:0] d, input logic [1:0] ta);
      send_hdr(2'b01, phy, r, n_ones, n_zeros);
      send_bit(ta[1]);
      send_bit(ta[0]);
      for (int i = 15; i >= 0; i--) send_bit(d[i]);
      @(negedge clk);
      chk(wr_stb && reg_addr == r && wr_data == d && !mdio_oe, "R6 write pulse",
          {wr_stb, reg_addr, wr_data}, {1'b1, r, d});
      mdio_in = 1'b1;
      @(negedge clk);
      chk(!wr_stb, "R6 single pulse", wr_stb, 0);
      writes_done++;
   endtask

   initial begin
      for (int i = 0; i < 32; i++) mem[i] = 16'h0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(!mdio_oe && !wr_stb && !rd_stb, "R1 reset state",
          {mdio_oe, wr_stb, rd_stb}, 0);

      // R2/R3/R6: first write sweep with varied idle and arming runs
      for (int r = 0; r < 32; r++)
         do_write(5'(r ^ 5'h15), 5'(r), r % 4, 1 + (r % 3), pat(r, 1), 2'(r));

      // R3/R5: read sweep with a different device address each frame
      for (int r = 0; r < 32; r++)
         do_read(5'(r * 7), 5'(r), 2, 1 + (r % 2), pat(r, 1), 1'b1);

      // R6: second sweep, both turnaround polarities
      for (int r = 0; r < 32; r++)
         do_write(5'(31 - r), 5'(r), 1, 1, pat(r, 2), (r % 2) ? 2'b11 : 2'b00);

      // R9: back-to-back reads, the release cycle carries the next arming 0
      for (int r = 0; r < 32; r++)
         do_read(5'(r), 5'(r), 0, (r == 0) ? 1 : 0, pat(r, 2), 1'b0);
      send_bit(1'b1);
      send_bit(1'b1);

      // R7: illegal opcodes abort with no strobes and no drive
      for (int k = 0; k < 2; k++) begin
         bit quiet;
         send_hdr(k ? 2'b11 : 2'b00, 5'd3, 5'd9, 2, 1);
         quiet = 1'b1;
         for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            quiet = quiet && !mdio_oe && !wr_stb && !rd_stb;
            mdio_in = 1'b1;
         end
         chk(quiet, "R7 illegal opcode quiet", quiet, 1);
         do_read(5'd0, 5'd9, 1, 1, pat(9, 2), 1'b1);
      end

      // R1: reset in the middle of a write frame
      send_hdr(2'b01, 5'd0, 5'd3, 1, 1);
      send_bit(1'b0);
      send_bit(1'b1);
      send_bit(1'b0);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      mdio_in = 1'b1;
      @(negedge clk);
      chk(!mdio_oe && !wr_stb && !rd_stb, "R1 reset mid-frame",
          {mdio_oe, wr_stb, rd_stb}, 0);
      do_read(5'd1, 5'd3, 3, 2, pat(3, 2), 1'b1);

      repeat (4) @(negedge clk);
      chk(oe_cycles == 17 * reads_done, "R8 drive cycles", oe_cycles, 17 * reads_done);
      chk(wr_pulses == writes_done, "R6 write count", wr_pulses, writes_done);
      chk(rd_pulses == reads_done, "R4 read count", rd_pulses, reads_done);

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule